// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM that holds 512K words of 8 bits. The host raises a one-cycle request with a direction bit, a 19-bit word address and a write byte whenever `ready` is high. The controller then runs one complete memory cycle and answers with a one-cycle `done` pulse. On a read, `rd_data` carries the captured byte in the same cycle as `done`.

On the memory side the controller drives the address, the three active-low strobes (chip select, output enable, write enable) and the outgoing half of the bidirectional data bus with its own drive enable. The incoming half of the bus comes back on `mem_dq_i`.

Every strobe width is a whole number of clock cycles. Each one is worked out at elaboration from the clock period and the selected speed grade, rounding each minimum time upward. A write holds chip select and write enable low together for long enough to meet the pulse, select-to-end, address-to-end and data-setup minimums. Before the next access, a recovery interval completes the write cycle. When a write follows a read, an idle turnaround separates the memory's release of the bus from the controller's drive.

Top module: `sram_ctl`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `ready` is 1. `done` is 0, `rd_data` is 0, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, and `mem_dq_oe` is 0.
- R2: Each time is converted to cycles as ceil(ns*1000/CLK_PERIOD_PS). `SPEED_GRADE`=0 selects write cycle 55, write pulse 40, select-to-end 45, address-to-end 45, data setup 25, read cycle 55, address access 55, enable access 25 and release 20 ns. `SPEED_GRADE`=1 selects 70, 50, 60, 60, 30, 70, 70, 35 and 25 ns. The write window is the largest of the pulse, select-to-end, address-to-end and data-setup counts (12 cycles at 4 ns, grade 0). The read window is the largest of the read-cycle and both access counts (14 cycles).
- R3: During a write, `mem_cs_n` and `mem_we_n` fall on the same edge and rise on the same edge, and `mem_oe_n` stays 1. `mem_addr` does not change while `mem_we_n` is low, nor on the edge that ends the write.
- R4: `mem_dq_oe` is 1 only in cycles where `mem_we_n` and `mem_cs_n` are both 0, and it is 1 in every such cycle.
- R5: The next falling edge of `mem_cs_n` after a write comes at least ceil(55 ns/T) cycles after that write started (14 cycles at 4 ns, grade 0).
- R6: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for exactly the read window. The value on `mem_dq_i` at the edge that ends the window appears on `rd_data` in the cycle where `done` is 1.
- R7: When a write follows a read, `mem_oe_n` is high for at least ceil(20 ns/T) cycles (5 at 4 ns) before `mem_dq_oe` rises.
- R8: A request raised while `ready` is 0 starts no memory cycle, produces no `done`, and changes no memory location.
- R9: While `mem_cs_n` is 1, both `mem_oe_n` and `mem_we_n` are 1.
- R10: Each accepted request yields exactly one `done`, which lasts one cycle. `ready` is 0 from the cycle after acceptance until the cycle of that `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken only when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write byte |
| ready | output | 1 | Controller idle, can accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DW | Captured read byte |
| mem_addr | output | AW | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DW | Outgoing data bus value |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | DW | Incoming data bus value |

## Verification
The assertions assume that the host changes `req_addr`, `req_wdata` and `req_write` only together with a request. They also assume that the memory model returns stable data on `mem_dq_i` for as long as a read holds its strobes. The stimulus meets both assumptions because the driver task updates the request fields only on the negative edge where it raises `req`. The memory model, in turn, refreshes `mem_dq_i` only on negative edges, from its stored array. The single deliberate out-of-protocol input is a request pulse raised while `ready` is low. It exercises the ignore rule, and the bench then checks the targeted address through a normal read.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_WRITE,
        ST_WREC,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } mem_ctl_t;

    typedef struct packed {
        int unsigned wcyc;
        int unsigned wpulse;
        int unsigned cs_end;
        int unsigned ad_end;
        int unsigned dsetup;
        int unsigned rcyc;
        int unsigned acc_a;
        int unsigned acc_oe;
        int unsigned release_t;
    } grade_ns_t;

    function automatic grade_ns_t grade_ns(input int unsigned grade);
        grade_ns_t g;
        if (grade == 0) begin
            g.wcyc = 55; g.wpulse = 40; g.cs_end = 45; g.ad_end = 45; g.dsetup = 25;
            g.rcyc = 55; g.acc_a = 55; g.acc_oe = 25; g.release_t = 20;
        end else begin
            g.wcyc = 70; g.wpulse = 50; g.cs_end = 60; g.ad_end = 60; g.dsetup = 30;
            g.rcyc = 70; g.acc_a = 70; g.acc_oe = 35; g.release_t = 25;
        end
        return g;
    endfunction

    function automatic int unsigned to_cyc(input int unsigned ns, input int unsigned per_ps);
        return (ns * 1000 + per_ps - 1) / per_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned wp_cycles(input int unsigned grade, input int unsigned per_ps);
        grade_ns_t g = grade_ns(grade);
        return umax(umax(to_cyc(g.wpulse, per_ps), to_cyc(g.cs_end, per_ps)),
                    umax(to_cyc(g.ad_end, per_ps), to_cyc(g.dsetup, per_ps)));
    endfunction

    function automatic int unsigned wr_cycles(input int unsigned grade, input int unsigned per_ps);
        grade_ns_t g = grade_ns(grade);
        int unsigned wc = to_cyc(g.wcyc, per_ps);
        int unsigned wp = wp_cycles(grade, per_ps);
        return (wc > wp + 1) ? wc - wp : 1;
    endfunction

    function automatic int unsigned rd_cycles(input int unsigned grade, input int unsigned per_ps);
        grade_ns_t g = grade_ns(grade);
        return umax(to_cyc(g.acc_a, per_ps),
                    umax(to_cyc(g.rcyc, per_ps), to_cyc(g.acc_oe, per_ps)));
    endfunction

    function automatic int unsigned hz_cycles(input int unsigned grade, input int unsigned per_ps);
        grade_ns_t g = grade_ns(grade);
        return umax(to_cyc(g.release_t, per_ps), 1);
    endfunction

    function automatic mem_ctl_t ctl_for(input seq_state_e s);
        mem_ctl_t c;
        c = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_WRITE: c = '{cs_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};
            ST_READ:  c = '{cs_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
            default:  c = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CNT_W'(1);
    end

    assign zero = (cnt == '0);

    // R2
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt == $past(cnt) - CNT_W'(1)));

endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          capture,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] mem_dq_i,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_o,
    output logic [DW-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr <= '0;
            mem_dq_o <= '0;
            rd_data  <= '0;
        end else begin
            if (accept) begin
                mem_addr <= req_addr;
                mem_dq_o <= req_wdata;
            end
            if (capture)
                rd_data <= mem_dq_i;
        end
    end

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned WP_CYC = 12,
    parameter int unsigned WR_CYC = 2,
    parameter int unsigned RD_CYC = 14,
    parameter int unsigned HZ_CYC = 5,
    parameter int          CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_write,
    input  logic             zero,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             done,
    output mem_ctl_t         ctl
);

    localparam logic [CNT_W-1:0] WP_LD = CNT_W'(WP_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] HZ_LD = CNT_W'(HZ_CYC - 1);

    seq_state_e state, nxt;
    logic       last_rd;
    logic       fin_any;

    assign ready  = (state == ST_IDLE);
    assign accept = ready && req;

    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = '0;
        fin_any  = 1'b0;
        capture  = 1'b0;
        case (state)
            ST_IDLE: if (req) begin
                load = 1'b1;
                if (!req_write) begin
                    nxt = ST_READ;  load_val = RD_LD;
                end else if (last_rd) begin
                    nxt = ST_TURN;  load_val = HZ_LD;
                end else begin
                    nxt = ST_WRITE; load_val = WP_LD;
                end
            end
            ST_TURN: if (zero) begin
                nxt = ST_WRITE; load = 1'b1; load_val = WP_LD;
            end
            ST_WRITE: if (zero) begin
                nxt = ST_WREC; load = 1'b1; load_val = WR_LD;
            end
            ST_WREC: if (zero) begin
                nxt = ST_IDLE; fin_any = 1'b1;
            end
            ST_READ: if (zero) begin
                nxt = ST_IDLE; fin_any = 1'b1; capture = 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctl     <= ctl_for(ST_IDLE);
            done    <= 1'b0;
            last_rd <= 1'b0;
        end else begin
            state <= nxt;
            ctl   <= ctl_for(nxt);
            done  <= fin_any;
            if (capture)
                last_rd <= 1'b1;
            else if (state == ST_WREC && zero)
                last_rd <= 1'b0;
        end
    end

    // R4
    drive_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.drive |-> (!ctl.we_n && !ctl.cs_n));

    // R9
    deselect_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.cs_n |-> (ctl.oe_n && ctl.we_n));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    read_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl.oe_n |-> (!ctl.cs_n && ctl.we_n && !ctl.drive));

    // R3
    strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.we_n) |-> $rose(ctl.cs_n));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned SPEED_GRADE   = 0,
    parameter int          AW            = 19,
    parameter int          DW            = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_i
);

    localparam int unsigned WP_CYC = wp_cycles(SPEED_GRADE, CLK_PERIOD_PS);
    localparam int unsigned WR_CYC = wr_cycles(SPEED_GRADE, CLK_PERIOD_PS);
    localparam int unsigned RD_CYC = rd_cycles(SPEED_GRADE, CLK_PERIOD_PS);
    localparam int unsigned HZ_CYC = hz_cycles(SPEED_GRADE, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC = umax(umax(WP_CYC, WR_CYC), umax(RD_CYC, HZ_CYC));
    localparam int          CNT_W  = $clog2(MAX_CYC + 1);

    logic             load, zero, accept, capture;
    logic [CNT_W-1:0] load_val;
    mem_ctl_t         ctl;

    sram_ctl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val), .zero(zero)
    );

    sram_ctl_seq #(
        .WP_CYC(WP_CYC), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC),
        .HZ_CYC(HZ_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .zero(zero), .load(load), .load_val(load_val),
        .ready(ready), .accept(accept), .capture(capture),
        .done(done), .ctl(ctl)
    );

    sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dpath (
        .clk(clk), .rst(rst), .accept(accept), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .rd_data(rd_data)
    );

    assign mem_cs_n  = ctl.cs_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.drive;

    // R8
    busy_addr_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(mem_addr));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> $stable(mem_addr));

endmodule

// File: tb/test_sram_ctl.sv
module test_sram_ctl;

    localparam int PER_PS = 4000;
    localparam int AW = 19;
    localparam int DW = 8;

    function automatic int ceil_cyc(input int ns);
        return (ns * 1000 + PER_PS - 1) / PER_PS;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int E_WP = imax(imax(ceil_cyc(40), ceil_cyc(45)), imax(ceil_cyc(45), ceil_cyc(25)));
    localparam int E_WC = ceil_cyc(55);
    localparam int E_RD = imax(ceil_cyc(55), imax(ceil_cyc(55), ceil_cyc(25)));
    localparam int E_HZ = ceil_cyc(20);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ready, done, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_o;
    logic [DW-1:0] mem_dq_i = 8'h3C;
    logic [AW-1:0] mem_addr;

    always #2 clk = ~clk;

    sram_ctl #(.CLK_PERIOD_PS(PER_PS), .SPEED_GRADE(0), .AW(AW), .DW(DW)) i_sram_ctl (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    int vectors = 0;
    int errors  = 0;
    int issued  = 0;
    int done_cnt = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    typedef struct { bit rd; logic [DW-1:0] d; } item_t;
    item_t sb[$];
    logic [DW-1:0] ref_mem [int];
    logic [DW-1:0] model_mem [int];

    task automatic do_op(input bit wr, input int a, input logic [DW-1:0] d);
        item_t it;
        while (!ready) @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
        it.rd = !wr;
        if (wr) begin
            ref_mem[a] = d;
            it.d = d;
        end else begin
            it.d = ref_mem.exists(a) ? ref_mem[a] : 8'hA5;
        end
        sb.push_back(it);
        issued++;
        @(negedge clk);
        req = 1'b0;
    endtask

    // R8: request pulse while busy must be dropped
    task automatic busy_poke(input int a, input logic [DW-1:0] d);
        while (ready) @(negedge clk);
        repeat (3) @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    // memory model and monitor
    int  we_run = 0, oe_run = 0, since_oe = 1000, since_ws = 1000;
    bit  last_wr = 0;
    logic we_p = 1, cs_p = 1, dq_p = 0, wr_p = 0;
    logic [DW-1:0] wr_hold;
    logic [AW-1:0] wr_addr;

    always @(negedge clk) begin
        bit wr_now;
        item_t it;
        if (!rst) begin
            wr_now = !mem_cs_n && !mem_we_n;
            // R4
            if (wr_now != mem_dq_oe) chk(0, "R4", int'(mem_dq_oe), int'(wr_now));
            if (wr_now && !wr_p) wr_addr = mem_addr;
            if (wr_now) begin
                wr_hold = mem_dq_o;
                // R3
                if (mem_addr != wr_addr || !mem_oe_n) chk(0, "R3", int'(mem_addr), int'(wr_addr));
            end
            if (!wr_now && wr_p) begin
                model_mem[int'(wr_addr)] = wr_hold;
                // R3 address still held on the edge ending the write
                chk(mem_addr == wr_addr, "R3", int'(mem_addr), int'(wr_addr));
            end
            mem_dq_i <= (!mem_cs_n && !mem_oe_n && mem_we_n) ?
                (model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'hA5) : 8'h3C;

            // R2: write window width
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin
                chk(we_run == E_WP, "R2", we_run, E_WP);
                we_run = 0;
            end
            // R6: read window width
            if (!mem_oe_n) oe_run++;
            else if (oe_run != 0) begin
                chk(oe_run == E_RD, "R6", oe_run, E_RD);
                oe_run = 0;
            end
            // R7: turnaround before drive
            if (mem_dq_oe && !dq_p) chk(since_oe >= E_HZ, "R7", since_oe, E_HZ);
            if (!mem_oe_n) since_oe = 0; else if (since_oe < 1000) since_oe++;
            // R5: write cycle length
            if (since_ws < 1000) since_ws++;
            if (!mem_we_n && we_p) begin since_ws = 0; last_wr = 1; end
            if (!mem_cs_n && cs_p && mem_we_n) begin
                if (last_wr) chk(since_ws >= E_WC, "R5", since_ws, E_WC);
                last_wr = 0;
            end
            if (!mem_cs_n && cs_p && !mem_we_n && since_ws != 0)
                chk(0, "R5", since_ws, E_WC);
            // R9
            if (mem_cs_n && (!mem_oe_n || !mem_we_n)) chk(0, "R9", int'(mem_oe_n), 1);
            // R10
            if (!ready && sb.size() == 0) chk(0, "R10", int'(ready), 1);
            if (done) begin
                done_cnt++;
                if (sb.size() == 0) chk(0, "R10", done_cnt, issued);
                else begin
                    it = sb.pop_front();
                    if (it.rd) chk(rd_data == it.d, "R6", int'(rd_data), int'(it.d));
                end
            end
            we_p = mem_we_n; cs_p = mem_cs_n; dq_p = mem_dq_oe; wr_p = wr_now;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1
        chk(ready == 1'b1, "R1", int'(ready), 1);
        chk(done == 1'b0, "R1", int'(done), 0);
        chk(rd_data == '0, "R1", int'(rd_data), 0);
        chk({mem_cs_n, mem_oe_n, mem_we_n} == 3'b111, "R1", int'({mem_cs_n, mem_oe_n, mem_we_n}), 7);
        chk(mem_dq_oe == 1'b0, "R1", int'(mem_dq_oe), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1 && mem_cs_n == 1'b1, "R1", int'(ready), 1);

        do_op(1, 0, 8'h11);
        do_op(1, 19'h7FFFF, 8'hEE);
        do_op(0, 0, 8'h00);
        do_op(0, 19'h7FFFF, 8'h00);
        do_op(1, 19'h2AAAA, 8'h5A);
        do_op(0, 19'h12345, 8'h00);
        do_op(1, 19'h15555, 8'hA5 ^ 8'hFF);
        do_op(0, 19'h2AAAA, 8'h00);
        do_op(0, 19'h15555, 8'h00);
        do_op(1, 0, 8'h00);
        do_op(0, 0, 8'h00);
        fork
            do_op(0, 19'h2AAAA, 8'h00);
            busy_poke(19'h33333, 8'h77);
        join
        do_op(0, 19'h33333, 8'h00);
        for (int i = 0; i < 6; i++) begin
            do_op(1, 19'h40000 + i, 8'(8'h20 + i * 7));
        end
        for (int i = 0; i < 6; i++) begin
            do_op(0, 19'h40000 + i, 8'h00);
        end

        while (sb.size() != 0 || !ready) @(negedge clk);
        repeat (3) @(negedge clk);
        // R8 / R10
        chk(done_cnt == issued, "R8", done_cnt, issued);
        chk(!model_mem.exists(19'h33333), "R8", 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        vectors++;
        errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", done_cnt, issued);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule